// File: doc/BRIEF.md
# Decode to micro-op queue transfer

This block sits between a fetch queue and a bounded micro-op queue. Each cycle it looks at a window of `WIN` head entries of the fetch queue. It then spends up to `DEC_W` decode slots to move entries across. A slot moves a whole unit of work: either every micro-op of one macro-instruction, or a complete run of trace-cache micro-ops. The fetch queue pops the number of entries reported on `pop_cnt_o` in the same cycle. The moved entries are presented to the micro-op queue one cycle later as a registered push bundle.

Each window lane has the following fields:
- a valid bit;
- a trace-cache-origin bit;
- a fetch-complete bit;
- a macro-op index, which is zero for the first micro-op of an instruction;
- a payload.

The fullness check happens only when a slot starts. The micro-op queue therefore needs headroom beyond `UQ_SIZE`. That headroom must be at least the longest instruction or trace run the window can carry.

Top module: `uop_xfer`

## Requirements
- R1: At most `DEC_W` (default 3) slots are used per cycle. With eight valid single-micro-op instructions in the window and a free queue, exactly 3 entries are popped.
- R2: A slot does not start when the lane at its head position is invalid (valid bit 0) or lies past the window. The cycle then moves nothing more.
- R3: A slot does not start when the effective occupancy is at or above `UQ_SIZE` (default 8). Effective occupancy is `uq_cnt_i` plus `push_cnt_o` plus the entries already moved earlier in the same cycle.
- R4: A head with trace-cache bit 1 moves, in that one slot, itself and every directly following valid lane whose trace-cache bit is 1. No further slot is used that cycle.
- R5: A head with trace-cache bit 0 and fetch-complete bit 0 uses up its slot without moving anything. Remaining slots in that cycle retry the same head.
- R6: A head with trace-cache bit 0 and fetch-complete bit 1 moves together with every directly following valid lane whose macro-op index is nonzero.
- R7: On the cycle after a transfer:
  - `push_cnt_o` equals the number popped.
  - Push lanes 0..n-1 carry the popped entries in window order, with their in-queue flag set to 1.
  - All other in-queue flags are 0.
- R8: Entries presented on the push bundle count toward occupancy in the slot-start check of that same cycle.
- R9: While `rst_ni` is low, `pop_cnt_o` and `push_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fq_vld_i | input | WIN | Window lane valid; lane 0 is the fetch-queue head |
| fq_tc_i | input | WIN | Lane came from the trace cache |
| fq_done_i | input | WIN | Lane's instruction-fetch access has completed |
| fq_mop_i | input | WIN*MOP_W | Macro-op index per lane |
| fq_data_i | input | WIN*DATA_W | Payload per lane |
| uq_cnt_i | input | UQ_CNT_W | Current micro-op queue occupancy |
| pop_cnt_o | output | POS_W | Entries to pop from the fetch queue this cycle |
| push_cnt_o | output | POS_W | Entries pushed into the micro-op queue this cycle |
| push_tc_o | output | WIN | Trace-cache bit of each push lane |
| push_mop_o | output | WIN*MOP_W | Macro-op index of each push lane |
| push_data_o | output | WIN*DATA_W | Payload of each push lane |
| push_inuq_o | output | WIN | In-micro-op-queue flag of each push lane |

## Verification
The assertions rely on one input rule. A valid head lane that is not from the trace cache always carries macro-op index zero, so the fetch queue never presents an instruction cut in half at its head. The stimulus keeps to this rule: every window starts on an instruction boundary. Between vectors the bench inserts an idle cycle with all lanes invalid, so pending pushes from one vector never leak into the next. The one exception is the directed test for R8, which applies the same window twice back to back on purpose.

// File: rtl/uop_xfer_pkg.sv
package uop_xfer_pkg;
  localparam int unsigned DEF_WIN    = 8;
  localparam int unsigned DEF_DEC_W  = 3;
  localparam int unsigned DEF_MOP_W  = 2;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_UQ_SZ  = 8;

  typedef enum logic [1:0] {
    SLOT_OFF,   // already stopped earlier in the cycle
    SLOT_BLOCK, // empty head or queue full
    SLOT_WAIT,  // fetch access outstanding
    SLOT_MOVE
  } slot_st_e;
endpackage

// File: rtl/uop_run_end.sv
module uop_run_end #(
  parameter int unsigned WIN   = 8,
  parameter int unsigned MOP_W = 2,
  parameter int unsigned POS_W = 4
) (
  input  logic [POS_W-1:0]     start_i,
  input  logic [WIN-1:0]       vld_i,
  input  logic [WIN-1:0]       tc_i,
  input  logic [WIN*MOP_W-1:0] mop_i,
  output logic [POS_W-1:0]     tc_end_o,
  output logic [POS_W-1:0]     ins_end_o
);
  logic tc_hit, ins_hit;

  // first lane after start that breaks each kind of run
  always_comb begin
    tc_end_o  = POS_W'(WIN);
    ins_end_o = POS_W'(WIN);
    tc_hit    = 1'b0;
    ins_hit   = 1'b0;
    for (int j = 0; j < WIN; j++) begin
      if (POS_W'(j) > start_i) begin
        if (!tc_hit && !(vld_i[j] && tc_i[j])) begin
          tc_end_o = POS_W'(j);
          tc_hit   = 1'b1;
        end
        if (!ins_hit && !(vld_i[j] && (mop_i[j*MOP_W +: MOP_W] != '0))) begin
          ins_end_o = POS_W'(j);
          ins_hit   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uop_slot.sv
module uop_slot
  import uop_xfer_pkg::*;
#(
  parameter int unsigned WIN     = 8,
  parameter int unsigned MOP_W   = 2,
  parameter int unsigned POS_W   = 4,
  parameter int unsigned OCC_W   = 6,
  parameter int unsigned UQ_SIZE = 8
) (
  input  logic [POS_W-1:0]     pos_i,
  input  logic                 stop_i,
  input  logic [OCC_W-1:0]     base_occ_i,
  input  logic [WIN-1:0]       vld_i,
  input  logic [WIN-1:0]       tc_i,
  input  logic [WIN-1:0]       done_i,
  input  logic [WIN*MOP_W-1:0] mop_i,
  output logic [POS_W-1:0]     pos_o,
  output logic                 stop_o
);
  localparam int unsigned XW = 1 << POS_W;

  logic [XW-1:0]    vld_x, tc_x, done_x;
  logic [OCC_W-1:0] occ;
  logic [POS_W-1:0] tc_end, ins_end;
  slot_st_e         st;

  assign vld_x  = XW'(vld_i);
  assign tc_x   = XW'(tc_i);
  assign done_x = XW'(done_i);
  assign occ    = base_occ_i + OCC_W'(pos_i);

  uop_run_end #(.WIN(WIN), .MOP_W(MOP_W), .POS_W(POS_W)) u_run (
    .start_i  (pos_i),
    .vld_i    (vld_i),
    .tc_i     (tc_i),
    .mop_i    (mop_i),
    .tc_end_o (tc_end),
    .ins_end_o(ins_end)
  );

  always_comb begin
    if (stop_i)                                          st = SLOT_OFF;
    else if (!vld_x[pos_i] || occ >= OCC_W'(UQ_SIZE))    st = SLOT_BLOCK;
    else if (!tc_x[pos_i] && !done_x[pos_i])             st = SLOT_WAIT;
    else                                                 st = SLOT_MOVE;
  end

  always_comb begin
    pos_o  = pos_i;
    stop_o = 1'b0;
    unique case (st)
      SLOT_OFF, SLOT_BLOCK: stop_o = 1'b1;
      SLOT_WAIT:            stop_o = 1'b0;
      SLOT_MOVE: begin
        // trace run ends the cycle
        pos_o  = tc_x[pos_i] ? tc_end : ins_end;
        stop_o = tc_x[pos_i];
      end
      default:              stop_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uop_push_reg.sv
module uop_push_reg #(
  parameter int unsigned WIN    = 8,
  parameter int unsigned MOP_W  = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned POS_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [POS_W-1:0]      pop_i,
  input  logic [WIN-1:0]        tc_i,
  input  logic [WIN*MOP_W-1:0]  mop_i,
  input  logic [WIN*DATA_W-1:0] data_i,
  output logic [POS_W-1:0]      cnt_o,
  output logic [WIN-1:0]        tc_o,
  output logic [WIN*MOP_W-1:0]  mop_o,
  output logic [WIN*DATA_W-1:0] data_o,
  output logic [WIN-1:0]        inuq_o
);
  logic [WIN-1:0]        take;
  logic [WIN*MOP_W-1:0]  mop_m;
  logic [WIN*DATA_W-1:0] data_m;

  for (genvar k = 0; k < WIN; k++) begin : g_lane
    assign take[k]                    = POS_W'(k) < pop_i;
    assign mop_m[k*MOP_W +: MOP_W]    = take[k] ? mop_i[k*MOP_W +: MOP_W] : '0;
    assign data_m[k*DATA_W +: DATA_W] = take[k] ? data_i[k*DATA_W +: DATA_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      tc_o   <= '0;
      mop_o  <= '0;
      data_o <= '0;
      inuq_o <= '0;
    end else begin
      cnt_o  <= pop_i;
      tc_o   <= tc_i & take;
      mop_o  <= mop_m;
      data_o <= data_m;
      inuq_o <= take;
    end
  end
endmodule

// File: rtl/uop_xfer.sv
module uop_xfer
  import uop_xfer_pkg::*;
#(
  parameter  int unsigned WIN      = DEF_WIN,
  parameter  int unsigned DEC_W    = DEF_DEC_W,
  parameter  int unsigned MOP_W    = DEF_MOP_W,
  parameter  int unsigned DATA_W   = DEF_DATA_W,
  parameter  int unsigned UQ_SIZE  = DEF_UQ_SZ,
  localparam int unsigned POS_W    = $clog2(WIN + 1),
  localparam int unsigned UQ_CNT_W = $clog2(UQ_SIZE + WIN + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WIN-1:0]        fq_vld_i,
  input  logic [WIN-1:0]        fq_tc_i,
  input  logic [WIN-1:0]        fq_done_i,
  input  logic [WIN*MOP_W-1:0]  fq_mop_i,
  input  logic [WIN*DATA_W-1:0] fq_data_i,
  input  logic [UQ_CNT_W-1:0]   uq_cnt_i,
  output logic [POS_W-1:0]      pop_cnt_o,
  output logic [POS_W-1:0]      push_cnt_o,
  output logic [WIN-1:0]        push_tc_o,
  output logic [WIN*MOP_W-1:0]  push_mop_o,
  output logic [WIN*DATA_W-1:0] push_data_o,
  output logic [WIN-1:0]        push_inuq_o
);
  localparam int unsigned OCC_W = $clog2(UQ_SIZE + 2 * WIN + 1) + 1;

  logic [POS_W-1:0] pos_c  [DEC_W+1];
  logic             stop_c [DEC_W+1];
  logic [OCC_W-1:0] base_occ;

  // pending push not yet reflected in uq_cnt_i
  assign base_occ  = OCC_W'(uq_cnt_i) + OCC_W'(push_cnt_o);
  assign pos_c[0]  = '0;
  assign stop_c[0] = !rst_ni;

  for (genvar s = 0; s < DEC_W; s++) begin : g_slot
    uop_slot #(
      .WIN(WIN), .MOP_W(MOP_W), .POS_W(POS_W), .OCC_W(OCC_W), .UQ_SIZE(UQ_SIZE)
    ) u_slot (
      .pos_i     (pos_c[s]),
      .stop_i    (stop_c[s]),
      .base_occ_i(base_occ),
      .vld_i     (fq_vld_i),
      .tc_i      (fq_tc_i),
      .done_i    (fq_done_i),
      .mop_i     (fq_mop_i),
      .pos_o     (pos_c[s+1]),
      .stop_o    (stop_c[s+1])
    );
  end

  assign pop_cnt_o = pos_c[DEC_W];

  uop_push_reg #(.WIN(WIN), .MOP_W(MOP_W), .DATA_W(DATA_W), .POS_W(POS_W)) u_push (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pop_i (pop_cnt_o),
    .tc_i  (fq_tc_i),
    .mop_i (fq_mop_i),
    .data_i(fq_data_i),
    .cnt_o (push_cnt_o),
    .tc_o  (push_tc_o),
    .mop_o (push_mop_o),
    .data_o(push_data_o),
    .inuq_o(push_inuq_o)
  );
endmodule

// File: rtl/uop_xfer_chk.sv
module uop_xfer_chk #(
  parameter int unsigned WIN      = 8,
  parameter int unsigned MOP_W    = 2,
  parameter int unsigned UQ_SIZE  = 8,
  parameter int unsigned POS_W    = 4,
  parameter int unsigned UQ_CNT_W = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [WIN-1:0]       fq_vld_i,
  input logic [WIN-1:0]       fq_tc_i,
  input logic [WIN-1:0]       fq_done_i,
  input logic [WIN*MOP_W-1:0] fq_mop_i,
  input logic [UQ_CNT_W-1:0]  uq_cnt_i,
  input logic [POS_W-1:0]     pop_cnt_o,
  input logic [POS_W-1:0]     push_cnt_o,
  input logic [WIN-1:0]       push_inuq_o
);
  logic room;
  assign room = (int'(uq_cnt_i) + int'(push_cnt_o)) < int'(UQ_SIZE);

  // R2
  empty_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fq_vld_i[0] |-> pop_cnt_o == '0);

  // R3
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !room |-> pop_cnt_o == '0);

  // R5
  fetch_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fq_vld_i[0] && !fq_tc_i[0] && !fq_done_i[0]) |-> pop_cnt_o == '0);

  // R6 input rule: non-trace head starts an instruction
  head_mop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fq_vld_i[0] && !fq_tc_i[0]) |-> fq_mop_i[MOP_W-1:0] == '0);

  // R4
  tc_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (room && fq_vld_i[0] && fq_tc_i[0] && fq_vld_i[1] && fq_tc_i[1]) |-> pop_cnt_o >= POS_W'(2));

  // R7
  push_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_cnt_o != '0 |=> push_cnt_o == $past(pop_cnt_o));

  // R7
  inuq_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(push_inuq_o) == int'(push_cnt_o));
endmodule

bind uop_xfer uop_xfer_chk #(
  .WIN(WIN), .MOP_W(MOP_W), .UQ_SIZE(UQ_SIZE), .POS_W(POS_W), .UQ_CNT_W(UQ_CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fq_vld_i   (fq_vld_i),
  .fq_tc_i    (fq_tc_i),
  .fq_done_i  (fq_done_i),
  .fq_mop_i   (fq_mop_i),
  .uq_cnt_i   (uq_cnt_i),
  .pop_cnt_o  (pop_cnt_o),
  .push_cnt_o (push_cnt_o),
  .push_inuq_o(push_inuq_o)
);

// File: tb/uop_xfer_test.sv
module uop_xfer_test;
  localparam int WIN = 8, MOP_W = 2, DATA_W = 8, NV = 15;

  // lane byte: {3'b0, vld, tc, done, mop[1:0]}, lane 0 in the top byte
  localparam logic [63:0] VW [NV] = '{
    64'h14141414_14000000, 64'h14151614_15141400, 64'h00000000_00000000,
    64'h18181918_14140000, 64'h14181814_00000000, 64'h10141414_00000000,
    64'h14151014_00000000, 64'h14141400_00000000, 64'h14151614_00000000,
    64'h14141400_00000000, 64'h14141414_14141414, 64'h18181818_18181818,
    64'h14141800_00000000, 64'h14001400_00000000, 64'h18141500_00000000};
  localparam logic [4:0] VU [NV] = '{0, 0, 0, 0, 0, 0, 0, 8, 7, 6, 0, 0, 0, 0, 0};
  localparam int         VP [NV] = '{3, 6, 0, 4, 3, 0, 2, 0, 3, 2, 3, 8, 3, 1, 1};
  localparam string      VR [NV] = '{"R1", "R6", "R2", "R4", "R4", "R5", "R5", "R3",
                                     "R3", "R3", "R1", "R4", "R4", "R2", "R4"};

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [WIN-1:0]        fq_vld, fq_tc, fq_done;
  logic [WIN*MOP_W-1:0]  fq_mop;
  logic [WIN*DATA_W-1:0] fq_data;
  logic [4:0]            uq_cnt;
  logic [3:0]            pop_cnt, push_cnt;
  logic [WIN-1:0]        push_tc, push_inuq;
  logic [WIN*MOP_W-1:0]  push_mop;
  logic [WIN*DATA_W-1:0] push_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uop_xfer uut (
    .clk_i(clk), .rst_ni(rst_ni), .fq_vld_i(fq_vld), .fq_tc_i(fq_tc),
    .fq_done_i(fq_done), .fq_mop_i(fq_mop), .fq_data_i(fq_data), .uq_cnt_i(uq_cnt),
    .pop_cnt_o(pop_cnt), .push_cnt_o(push_cnt), .push_tc_o(push_tc),
    .push_mop_o(push_mop), .push_data_o(push_data), .push_inuq_o(push_inuq));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] w, logic [4:0] uq, int base);
    for (int k = 0; k < WIN; k++) begin
      logic [7:0] b;
      b = w[63-8*k -: 8];
      fq_vld[k]  = b[4];
      fq_tc[k]   = b[3];
      fq_done[k] = b[2];
      fq_mop[k*MOP_W +: MOP_W]    = b[1:0];
      fq_data[k*DATA_W +: DATA_W] = {base[4:0], k[2:0]};
    end
    uq_cnt = uq;
  endtask

  // R7: lanes below n carry window data in order with flag set, others clear
  task automatic check_push(string req, int n, int base);
    int bad = 0;
    check(req, int'(push_cnt), n);
    for (int k = 0; k < WIN; k++) begin
      if (k < n) begin
        if (push_data[k*DATA_W +: DATA_W] != {base[4:0], k[2:0]} || !push_inuq[k]) bad++;
      end else if (push_inuq[k]) bad++;
    end
    check("R7 lanes", bad, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    drive(VW[0], 5'd0, 0);
    @(negedge clk); @(negedge clk);
    #2;
    check("R9 pop in reset", int'(pop_cnt), 0);
    check("R9 push in reset", int'(push_cnt), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    drive('0, 5'd0, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VW[i], VU[i], i);
      #2;
      check(VR[i], int'(pop_cnt), VP[i]);
      @(negedge clk);
      drive('0, 5'd0, 0);
      #2;
      check_push("R7", VP[i], i);
    end

    // R8: pending push counts toward occupancy
    @(negedge clk);
    drive(64'h14141400_00000000, 5'd5, 20);
    #2;
    check("R8 first", int'(pop_cnt), 3);
    @(negedge clk);
    #2;
    check("R8 pending blocks", int'(pop_cnt), 0);
    check_push("R7", 3, 20);
    @(negedge clk);
    #2;
    check("R8 after push", int'(pop_cnt), 3);
    @(negedge clk);
    drive('0, 5'd0, 0);
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule